// File: doc/BRIEF.md
# Multi-Level Cell Page Program Sequencer

This block programs one page of two-bit-per-cell flash by incremental step pulses. Each bitline gets a target two-bit level. A single phase input picks the upper-page pass or the lower-page pass. After a start request the block issues a train of word-line pulses, and the amplitude code rises by one step from each pulse to the next. After every pulse, once the pulse is off, it asks the sense stage to compare each bitline against the reference that bitline needs in this phase. Bitlines that have reached their reference are put at the inhibit level and receive no further charge. Bitlines that need no charge in this phase are inhibited before the first pulse.

The upper pass always comes first. It raises every cell whose upper bit is 0 to the middle reference. The lower pass then moves cells from the erased level to the lowest programmed level, or from the middle level to the highest. The block ends with a one-cycle done when every bitline is inhibited. It ends with a one-cycle fail when the pulse budget runs out first. Voltage generation and the cell array lie outside the block.

Top module: `mlc_prog_seq`

## Requirements
- R1: After reset, busy, done, fail, pulse_en and verify_req are 0, amp_code is 0, every inhibit bit is 1 and every verify_ref field is 0.
- R2: Bitline i takes its level from target_lvl[2i+1:2i], where bit 2i+1 is the upper bit. Levels in rising threshold order are 11 (erased), 10, 01, 00. In the upper phase (mode_lower=0), a bitline whose upper bit is 0 gets verify_ref code 2 (middle reference) and starts uninhibited. Every other bitline gets code 0 and is inhibited from the first pulse.
- R3: In the lower phase (mode_lower=1), level 10 gets verify_ref code 1 (lowest reference) and level 00 gets code 3 (highest reference), and both start uninhibited. Levels 11 and 01 get code 0 and are inhibited from the first pulse.
- R4: Every pulse slot is pulse_en high for one cycle, then verify_req high in the next cycle, then the cycle in which sense_ok is sampled. pulse_en and verify_req are never high in the same cycle. The first pulse_en comes in the second cycle after the cycle in which start is accepted.
- R5: The first pulse of an operation carries amp_code 0, and each later pulse carries the previous code plus 1.
- R6: A bitline whose sense_ok bit is 1 in the sample cycle becomes inhibited and stays inhibited until the next operation is loaded. sense_ok in any other cycle has no effect.
- R7: When all bitlines are inhibited, done is high for exactly one cycle, busy falls in that cycle, and no further pulse is issued. If all bitlines are inhibited at load, done follows with zero pulses.
- R8: If some bitline is still uninhibited after MAX_PULSES pulses, fail is high for exactly one cycle, busy falls, and no further pulse is issued.
- R9: start while busy is ignored. The running operation keeps its phase, its references and its pulse count.
- R10: The inhibit vector changes only at the end of a sample cycle or at load. It is constant in every pulse cycle and every verify cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode_lower | input | 1 | 0 = upper-page phase, 1 = lower-page phase |
| target_lvl | input | 2*NUM_BL | Two-bit target level per bitline |
| sense_ok | input | NUM_BL | Per-bitline comparator result, valid the cycle after verify_req |
| pulse_en | output | 1 | Word-line program pulse |
| amp_code | output | AMP_W | Pulse amplitude step |
| verify_req | output | 1 | Request a sense against verify_ref |
| verify_ref | output | 2*NUM_BL | Per-bitline reference code (0 none, 1 low, 2 mid, 3 high) |
| inhibit | output | NUM_BL | Per-bitline inhibit level select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle pulse-budget exhaustion |

## Verification
The bench drives sense_ok to all ones in every cycle except the true sample cycle. A design that samples sense_ok at the wrong time therefore inhibits bitlines early, and their final thresholds stay below the reference. A behavioural cell model adds charge per pulse, so a bitline inhibited one pulse late overshoots the window of one step above its reference, and one that is inhibited early stops short of it. The other corner cases covered are an operation that needs zero pulses, exhaustion of the budget at exactly MAX_PULSES pulses with the amplitude stopping at its last code, a start issued mid-run that a faulty design would take as a reload, and lower-phase targets that start from the middle level rather than the erased one.

// File: rtl/mlc_prog_pkg.sv
package mlc_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULSE,
    ST_VERIFY,
    ST_SAMPLE
  } seq_state_t;

  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_LO   = 2'd1,
    REF_MID  = 2'd2,
    REF_HI   = 2'd3
  } vref_t;

  // Reference a bitline must reach in the selected phase.
  function automatic vref_t pick_ref(input logic lower_mode, input logic [1:0] lvl);
    vref_t r;
    if (!lower_mode) begin
      r = lvl[1] ? REF_NONE : REF_MID;
    end else begin
      case (lvl)
        2'b10:   r = REF_LO;
        2'b00:   r = REF_HI;
        default: r = REF_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/mlc_bl_lane.sv
module mlc_bl_lane
  import mlc_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       lower_mode,
  input  logic [1:0] level,
  input  logic       sample_en,
  input  logic       sense_bit,
  output logic       inhibit_o,
  output logic [1:0] ref_o
);

  vref_t ref_q;
  logic  inh_q;
  vref_t ref_d;

  always_comb ref_d = pick_ref(lower_mode, level);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= REF_NONE;
      inh_q <= 1'b1;
    end else if (load) begin
      ref_q <= ref_d;
      inh_q <= (ref_d == REF_NONE);
    end else if (sample_en && sense_bit) begin
      inh_q <= 1'b1;
    end
  end

  assign inhibit_o = inh_q;
  assign ref_o     = ref_q;

  // R6: once inhibited, a bitline stays inhibited until the next load
  p_inh_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (inh_q && !load) |=> inh_q);

  // R6: sense outside the sample cycle leaves the lane untouched
  p_sense_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !sample_en) |=> $stable(inh_q));

  // R9: the reference only changes on an accepted load
  p_ref_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ref_q));

endmodule

// File: rtl/mlc_pulse_ctl.sv
module mlc_pulse_ctl
  import mlc_prog_pkg::*;
#(
  parameter int MAX_PULSES = 16,
  parameter int AMP_W      = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             all_inh,
  output logic             load,
  output logic             sample_en,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             pulse_en,
  output logic             verify_req,
  output logic [AMP_W-1:0] amp_code
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PULSES);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign load      = (state == ST_IDLE) && start;
  assign sample_en = (state == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      pulse_en   <= 1'b0;
      verify_req <= 1'b0;
      amp_code   <= '0;
    end else begin
      done       <= 1'b0;
      fail       <= 1'b0;
      pulse_en   <= 1'b0;
      verify_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_CHECK;
            busy     <= 1'b1;
            cnt      <= '0;
            amp_code <= '0;
          end
        end
        ST_CHECK: begin
          if (all_inh) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (cnt == LIMIT) begin
            fail  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            pulse_en <= 1'b1;
            amp_code <= cnt[AMP_W-1:0];
            state    <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          verify_req <= 1'b1;
          state      <= ST_VERIFY;
        end
        ST_VERIFY: state <= ST_SAMPLE;
        ST_SAMPLE: begin
          cnt   <= cnt + 1'b1;
          state <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a pulse is followed by its verify request
  p_pulse_then_verify_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_en |=> verify_req);

  // R4: never pulse and sense together
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_en |-> !verify_req);

  // R5: consecutive pulses step the amplitude by one
  p_amp_step_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_en && $past(pulse_en, 4)) |-> (amp_code == $past(amp_code, 4) + 1'b1));

  // R8: fail only once the budget is spent
  p_fail_limit_r8: assert property (@(posedge clk) disable iff (rst)
    fail |-> (cnt == LIMIT));

  // R7: completion ends the operation and is exclusive with fail
  p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (!busy && !(done && fail)));

  // R7: no pulse or sense outside an operation
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pulse_en && !verify_req));

endmodule

// File: rtl/mlc_prog_seq.sv
module mlc_prog_seq #(
  parameter int NUM_BL     = 8,
  parameter int MAX_PULSES = 16,
  parameter int AMP_W      = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode_lower,
  input  logic [2*NUM_BL-1:0] target_lvl,
  input  logic [NUM_BL-1:0]   sense_ok,
  output logic                pulse_en,
  output logic [AMP_W-1:0]    amp_code,
  output logic                verify_req,
  output logic [2*NUM_BL-1:0] verify_ref,
  output logic [NUM_BL-1:0]   inhibit,
  output logic                busy,
  output logic                done,
  output logic                fail
);

  logic load;
  logic sample_en;
  logic all_inh;

  assign all_inh = &inhibit;

  mlc_pulse_ctl #(
    .MAX_PULSES (MAX_PULSES),
    .AMP_W      (AMP_W)
  ) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .all_inh    (all_inh),
    .load       (load),
    .sample_en  (sample_en),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .pulse_en   (pulse_en),
    .verify_req (verify_req),
    .amp_code   (amp_code)
  );

  for (genvar g = 0; g < NUM_BL; g++) begin : g_lane
    mlc_bl_lane lane_i (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .lower_mode (mode_lower),
      .level      (target_lvl[2*g +: 2]),
      .sample_en  (sample_en),
      .sense_bit  (sense_ok[g]),
      .inhibit_o  (inhibit[g]),
      .ref_o      (verify_ref[2*g +: 2])
    );
  end

  // R7: done only when every bitline is inhibited
  p_done_all_inh_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (&inhibit));

  // R10: inhibit levels hold through pulse and verify cycles
  p_inh_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (pulse_en || verify_req) |-> $stable(inhibit));

endmodule

// File: tb/mlc_prog_seq_tb.sv
`timescale 1ns/1ps
module mlc_prog_seq_tb_top;
  localparam int NB = 8;
  localparam int MAXP = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_lower = 1'b0;
  logic [2*NB-1:0] target_lvl = '1;
  logic [NB-1:0] sense_ok = '0;
  logic pulse_en, verify_req, busy, done, fail;
  logic [AW-1:0] amp_code;
  logic [2*NB-1:0] verify_ref;
  logic [NB-1:0] inhibit;

  always #10 clk = ~clk;

  mlc_prog_seq #(.NUM_BL(NB), .MAX_PULSES(MAXP), .AMP_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_lower(mode_lower),
    .target_lvl(target_lvl), .sense_ok(sense_ok), .pulse_en(pulse_en),
    .amp_code(amp_code), .verify_req(verify_req), .verify_ref(verify_ref),
    .inhibit(inhibit), .busy(busy), .done(done), .fail(fail));

  int n_chk = 0;
  int n_bad = 0;
  int th[NB];
  int gain[NB];
  int th0[NB];
  int pulse_idx = 0;
  int mon_err = 0;
  bit vseen = 0;
  bit prev_pulse = 0;
  logic [NB-1:0] prev_inh = '1;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int refv(input int code);
    case (code)
      1: return 10;
      2: return 20;
      3: return 30;
      default: return 0;
    endcase
  endfunction

  // Expected reference code per requirement R2 / R3
  function automatic int exp_code(input bit lower, input logic [1:0] lvl);
    if (!lower) return lvl[1] ? 0 : 2;
    if (lvl == 2'b10) return 1;
    if (lvl == 2'b00) return 3;
    return 0;
  endfunction

  // Cell model, protocol monitor and sense driver
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse_en) begin
        if (amp_code != AW'(pulse_idx)) mon_err++;
        pulse_idx++;
        for (int i = 0; i < NB; i++) if (!inhibit[i]) th[i] += gain[i];
        if (verify_req) mon_err++;
      end
      if (prev_pulse && !verify_req) mon_err++;
      if ((pulse_en || verify_req) && inhibit !== prev_inh) mon_err++;
      if (!busy && (pulse_en || verify_req)) mon_err++;
    end
    for (int i = 0; i < NB; i++)
      sense_ok[i] = vseen ? (verify_ref[2*i +: 2] != 2'd0 && th[i] >= refv(int'(verify_ref[2*i +: 2])))
                          : 1'b1;
    vseen = verify_req;
    prev_pulse = pulse_en;
    prev_inh = inhibit;
  end

  task automatic run_op(input bit lower, input logic [2*NB-1:0] tg, input string tag,
                        input int inject_at, output int pulses, output bit got_done, output bit got_fail);
    int e;
    for (int i = 0; i < NB; i++) th0[i] = th[i];
    pulse_idx = 0;
    mon_err = 0;
    @(negedge clk);
    mode_lower = lower; target_lvl = tg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {tag, " R9 busy after start"}, busy, 1);
    for (int i = 0; i < NB; i++) begin
      e = exp_code(lower, tg[2*i +: 2]);
      chk(verify_ref[2*i +: 2] == e[1:0], {tag, " R2 R3 ref code"}, verify_ref[2*i +: 2], e);
      chk(inhibit[i] == (e == 0), {tag, " R2 R3 initial inhibit"}, inhibit[i], e == 0);
    end
    got_done = 0; got_fail = 0;
    for (int k = 0; k < 500; k++) begin
      if (inject_at > 0 && k == inject_at) begin
        start = 1'b1; mode_lower = ~lower; target_lvl = ~tg;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done || fail) begin
        got_done = done; got_fail = fail;
        chk(busy === 1'b0, {tag, " R7 R8 busy low at end"}, busy, 0);
        if (done) chk(&inhibit, {tag, " R7 all inhibited at done"}, inhibit, '1);
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done && !fail, {tag, " R7 R8 single-cycle end pulse"}, {done, fail}, 0);
    repeat (6) @(negedge clk);
    pulses = pulse_idx;
    chk(mon_err == 0, {tag, " R4 R5 R10 pulse protocol"}, mon_err, 0);
  endtask

  function automatic logic [2*NB-1:0] pack(input logic [1:0] l[NB]);
    logic [2*NB-1:0] v;
    for (int i = 0; i < NB; i++) v[2*i +: 2] = l[i];
    return v;
  endfunction

  task automatic check_lanes(input bit lower, input logic [2*NB-1:0] tg, input string tag);
    int c;
    for (int i = 0; i < NB; i++) begin
      c = exp_code(lower, tg[2*i +: 2]);
      if (c == 0)
        chk(th[i] == th0[i], {tag, " R2 R3 inhibited lane untouched"}, th[i], th0[i]);
      else
        chk(th[i] >= refv(c) && th[i] < refv(c) + gain[i], {tag, " R6 lane stops at reference"}, th[i], refv(c));
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R1 status idle", {busy, done, fail}, 0);
    chk(!pulse_en && !verify_req, "R1 no pulse", {pulse_en, verify_req}, 0);
    chk(amp_code == 0, "R1 amp zero", amp_code, 0);
    chk(inhibit == '1, "R1 all inhibited", inhibit, '1);
    chk(verify_ref == '0, "R1 refs zero", verify_ref, 0);
  endtask

  logic [1:0] mix[NB] = '{2'b11, 2'b10, 2'b01, 2'b00, 2'b00, 2'b01, 2'b11, 2'b10};

  task automatic t_upper(input int inject_at, input string tag);
    int p; bit d, f;
    gain = '{3, 3, 3, 4, 5, 2, 3, 3};
    for (int i = 0; i < NB; i++) th[i] = 0;
    run_op(1'b0, pack(mix), tag, inject_at, p, d, f);
    chk(d && !f, {tag, " R7 done"}, d, 1);
    chk(p == 10, {tag, " R5 R9 pulse count"}, p, 10);
    check_lanes(1'b0, pack(mix), tag);
  endtask

  task automatic t_lower();
    int p; bit d, f;
    gain = '{2, 3, 2, 1, 4, 2, 2, 10};
    for (int i = 0; i < NB; i++) th[i] = mix[i][1] ? 0 : 22;
    run_op(1'b1, pack(mix), "lower", 0, p, d, f);
    chk(d && !f, "lower R7 done", d, 1);
    chk(p == 8, "lower R3 pulse count", p, 8);
    check_lanes(1'b1, pack(mix), "lower");
  endtask

  task automatic t_zero(input bit lower);
    int p; bit d, f;
    logic [1:0] l[NB];
    for (int i = 0; i < NB; i++) begin
      l[i] = (lower && i[0]) ? 2'b01 : 2'b11;
      th[i] = 5; gain[i] = 1;
    end
    run_op(lower, pack(l), "zero", 0, p, d, f);
    chk(d && !f, "zero R7 done without pulses", d, 1);
    chk(p == 0, "zero R7 pulse count", p, 0);
  endtask

  task automatic t_fail();
    int p; bit d, f;
    logic [1:0] l[NB];
    for (int i = 0; i < NB; i++) begin l[i] = 2'b11; th[i] = 0; gain[i] = 1; end
    l[0] = 2'b00; l[1] = 2'b01; gain[1] = 5;
    run_op(1'b0, pack(l), "fail", 0, p, d, f);
    chk(f && !d, "R8 fail raised", f, 1);
    chk(p == MAXP, "R8 pulse budget", p, MAXP);
    chk(th[0] == MAXP, "R8 slow lane charge", th[0], MAXP);
    chk(th[1] >= 20 && th[1] < 25, "R6 fast lane stops", th[1], 20);
    chk(amp_code == AW'(MAXP - 1), "R5 last amplitude", amp_code, MAXP - 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin th[i] = 0; gain[i] = 1; end
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_upper(0, "upper");
    t_lower();
    t_zero(1'b0);
    t_zero(1'b1);
    t_fail();
    t_upper(8, "restart R9");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule